// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it counts out a fixed power-up pause, then runs a batch of wake-up RAS cycles. Only after the last of these does it raise `init_done`, which tells the access controller that normal reads and writes may start. From then on an interval timer schedules one refresh per slot. Its period is the retention window divided by the number of rows, both given as parameters.

Every refresh is a CAS-before-RAS cycle, so the memory supplies its own row address and the address bus is not used. The sequencer never takes the strobes by force. It raises `ref_req`, and it drives a cycle only while the access controller returns `ref_gnt`. Refreshes that fall due while the host keeps the bus are counted as pending. They are issued back to back once the grant arrives. If one more refresh falls due while the pending count is already at its limit, the retention deadline is taken as missed. The sequencer then pulses `deadline_miss`, drops `init_done` and repeats the full wake-up batch.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, and for exactly PAUSE_US*CLK_MHZ cycles after it is released, `ref_req` and `init_done` are low and `ras_n`/`cas_n` are high. `ref_req` rises on the next cycle.
- R2: After the pause exactly WAKE_CYC refresh cycles are issued, and `init_done` rises only after the last of them.
- R3: In every cycle issued, `cas_n` falls first and stays low for exactly T_CSR clocks before `ras_n` falls. `ras_n` falls only while `cas_n` is low.
- R4: `ras_n` stays low for exactly T_RAS clocks. Both strobes are high for at least T_RP clocks before the next cycle starts.
- R5: `we_n` and `oe_n` are high whenever a strobe is low, so no data access takes place and the data pins stay undriven.
- R6: A strobe goes low only while `ref_gnt` is high. While the grant is withheld both strobes stay high, even though `ref_req` stays asserted.
- R7: Once initialised, with the grant always given, successive refresh cycles start exactly CLK_MHZ*WINDOW_US/REF_ROWS clocks apart.
- R8: Refreshes that fall due while the grant is withheld are counted as pending, up to PEND_MAX. All of them are issued back to back once the grant returns.
- R9: A refresh that falls due while PEND_MAX are already pending pulses `deadline_miss` for one cycle, drops `init_done` and clears the pending count. WAKE_CYC wake-up cycles are then issued again before `init_done` rises.
- R10: `ref_req` is high while wake-up or pending refresh work remains or a cycle is in progress, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Bus granted to the sequencer by the access controller |
| ref_req | output | 1 | Sequencer needs the bus |
| init_done | output | 1 | Wake-up complete; host accesses allowed |
| deadline_miss | output | 1 | One-cycle pulse when a refresh slot is lost |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| oe_n | output | 1 | Output enable to the DRAM, held high |

## Verification
The hardest state to reach from the ports is a lost refresh slot. Reaching it needs PEND_MAX refreshes to build up behind a withheld grant, and then one more timer expiry before the grant returns. The bench uses short parameters and restarts from reset for each table row, so the timer phase is known from the rise of `init_done`. It withholds the grant for a chosen number of whole intervals plus a margin. The row with PEND_MAX+1 intervals must show the miss pulse, the full wake-up batch on release, and `init_done` high again. The rows with fewer intervals must show exactly that many back-to-back cycles and no miss.

// File: rtl/dram_rfsh_pkg.sv
// Package: shared state encodings for the refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dram_rfsh_pkg;
    typedef enum logic [1:0] {PH_PAUSE, PH_WAKE, PH_RUN} phase_t;
    typedef enum logic [1:0] {ST_IDLE, ST_CAS, ST_RAS, ST_PRE} strobe_t;
endpackage

// File: rtl/rfsh_tick_timer.sv
// Module: free-running period timer that emits a one-cycle tick every
// PERIOD cycles while run is high, and restarts from zero when run drops.
// Assumes: PERIOD >= 1.
module rfsh_tick_timer #(
    parameter int PERIOD = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Count cycles within the period; hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/rfsh_pend_ctr.sv
// Module: saturating counter of refreshes owed to the DRAM.
// Assumes: inc and dec may coincide; clr wins over both.
module rfsh_pend_ctr #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic full
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] MAXV = PW'(PEND_MAX);

    logic [PW-1:0] cnt;

    // Track owed refreshes; an increment at the limit is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc && !dec && cnt != MAXV) cnt <= cnt + 1'b1;
        else if (dec && !inc && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign nonzero = (cnt != '0);
    assign full    = (cnt == MAXV);

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAXV); // R8
endmodule

// File: rtl/cbr_strobe_fsm.sv
// Module: drives one CAS-before-RAS cycle per start: CAS alone for T_CSR
// clocks, CAS and RAS low for T_RAS clocks, then both high for T_RP clocks.
// Assumes: start is ignored unless idle; all timings >= 1.
module cbr_strobe_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_RAS = 10,
    parameter int T_RP  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic done
);
    localparam int TMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_RAS > T_RP) ? T_RAS : T_RP);
    localparam int TW = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [TW-1:0] CSR_L = TW'(T_CSR - 1);
    localparam logic [TW-1:0] RAS_L = TW'(T_RAS - 1);
    localparam logic [TW-1:0] RP_L  = TW'(T_RP - 1);

    strobe_t st;
    logic [TW-1:0] tcnt;

    // Step through the strobe phases, timing each with tcnt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            tcnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin st <= ST_CAS; tcnt <= '0; end
                ST_CAS:  if (tcnt == CSR_L) begin st <= ST_RAS; tcnt <= '0; end
                         else tcnt <= tcnt + 1'b1;
                ST_RAS:  if (tcnt == RAS_L) begin st <= ST_PRE; tcnt <= '0; end
                         else tcnt <= tcnt + 1'b1;
                ST_PRE:  if (tcnt == RP_L) begin st <= ST_IDLE; tcnt <= '0; end
                         else tcnt <= tcnt + 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cas_n = !(st == ST_CAS || st == ST_RAS);
    assign ras_n = !(st == ST_RAS);
    assign busy  = (st != ST_IDLE);
    assign done  = (st == ST_PRE) && (tcnt == RP_L);

    // Checker state: length of the current RAS-low and RAS-high runs.
    logic [15:0] lo_len, hi_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_len <= '0;
            hi_len <= 16'(T_RP);
        end else begin
            lo_len <= ras_n ? '0 : lo_len + 1'b1;
            if (!ras_n) hi_len <= '0;
            else if (hi_len < 16'(T_RP)) hi_len <= hi_len + 1'b1;
        end
    end

    AST_RAS_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n)); // R3
    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> lo_len == 16'(T_RAS)); // R4
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> hi_len >= 16'(T_RP)); // R4
endmodule

// File: rtl/dram_refresh_seq.sv
// Module: top of the refresh sequencer. Runs the power-up pause and the
// wake-up batch, then schedules periodic CAS-before-RAS refreshes through a
// request/grant handshake. A lost slot restarts the wake-up batch.
// Assumes: the access controller holds ref_gnt for as long as ref_req is high
// once it has granted; WAKE_CYC >= 1; the interval is longer than a cycle.
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int PAUSE_US  = 200,
    parameter int WINDOW_US = 32000,
    parameter int REF_ROWS  = 2048,
    parameter int WAKE_CYC  = 8,
    parameter int PEND_MAX  = 8,
    parameter int T_CSR     = 1,
    parameter int T_RAS     = 10,
    parameter int T_RP      = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic init_done,
    output logic deadline_miss,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n
);
    localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
    localparam int REF_INT   = (CLK_MHZ * WINDOW_US) / REF_ROWS;
    localparam int WW        = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WAKE_N = WW'(WAKE_CYC);

    phase_t        phase;
    logic [WW-1:0] wake_left;
    logic          pause_tick, intv_tick, pend_nz, pend_full;
    logic          busy, done, start, work, miss;

    rfsh_tick_timer #(.PERIOD(PAUSE_CYC)) u_pause (
        .clk(clk), .rst_n(rst_n), .run(phase == PH_PAUSE), .tick(pause_tick));

    rfsh_tick_timer #(.PERIOD(REF_INT)) u_intv (
        .clk(clk), .rst_n(rst_n), .run(phase == PH_RUN), .tick(intv_tick));

    rfsh_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr(phase != PH_RUN), .inc(intv_tick),
        .dec(done && phase == PH_RUN), .nonzero(pend_nz), .full(pend_full));

    cbr_strobe_fsm #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ras_n(ras_n), .cas_n(cas_n),
        .busy(busy), .done(done));

    assign miss  = (phase == PH_RUN) && intv_tick && pend_full;
    assign work  = (phase == PH_WAKE) ? (wake_left != '0)
                 : (phase == PH_RUN)  ? pend_nz : 1'b0;
    assign start = work && ref_gnt && !busy;

    // Phase control: pause, wake-up batch, run; a lost slot returns to wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_PAUSE;
            wake_left <= '0;
        end else begin
            case (phase)
                PH_PAUSE: if (pause_tick) begin
                    phase     <= PH_WAKE;
                    wake_left <= WAKE_N;
                end
                PH_WAKE: if (done && wake_left != '0) begin
                    wake_left <= wake_left - 1'b1;
                    if (wake_left == WW'(1)) phase <= PH_RUN;
                end
                PH_RUN: if (miss) begin
                    phase     <= PH_WAKE;
                    wake_left <= WAKE_N;
                end
                default: phase <= PH_PAUSE;
            endcase
        end
    end

    assign ref_req       = work || busy;
    assign init_done     = (phase == PH_RUN);
    assign deadline_miss = miss;
    assign we_n          = 1'b1;
    assign oe_n          = 1'b1;

    AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(ref_gnt)); // R6
    AST_INIT_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(done)); // R2
    AST_MISS_REWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        deadline_miss |=> !init_done); // R9
    AST_QUIET_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAUSE) |-> (ras_n && cas_n && !ref_req)); // R1
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
// Bench: table of grant-withholding scenarios followed by directed tests.
module dram_refresh_seq_tb_top;
    localparam int CLK_MHZ = 1, PAUSE_US = 50, WINDOW_US = 200, REF_ROWS = 2;
    localparam int WAKE_CYC = 8, PEND_MAX = 4, T_CSR = 2, T_RAS = 3, T_RP = 2;
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int REF_INT   = CLK_MHZ * WINDOW_US / REF_ROWS;

    // Scenario table: intervals withheld, expected cycles after release, miss.
    localparam int NV = 5;
    localparam int V_INTV [NV] = '{0, 1, 2, 4, 5};
    localparam int V_EXP  [NV] = '{0, 1, 2, 4, 8};
    localparam int V_MISS [NV] = '{0, 0, 0, 0, 1};

    logic clk = 1'b0, rst_n = 1'b0, allow = 1'b1;
    logic ref_gnt, ref_req, init_done, deadline_miss, ras_n, cas_n, we_n, oe_n;
    int n_chk = 0, n_err = 0, falls = 0, cyc = 0;
    int t_prev = 0, t_last = 0;
    int cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 1000;
    logic prev_ras = 1'b1, prev_cas = 1'b1, miss_seen = 1'b0;

    always #2.5 clk = ~clk;
    assign ref_gnt = ref_req && allow;

    dram_refresh_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .WINDOW_US(WINDOW_US),
        .REF_ROWS(REF_ROWS), .WAKE_CYC(WAKE_CYC), .PEND_MAX(PEND_MAX),
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .init_done(init_done), .deadline_miss(deadline_miss), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n));

    function automatic void chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Strobe monitor, sampled on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                falls++;
                t_prev = t_last;
                t_last = cyc;
                chk(!prev_cas, "R3 cas low before ras", prev_cas, 0);
                chk(cas_lo_run == T_CSR, "R3 cas lead", cas_lo_run, T_CSR);
                chk(ras_hi_run >= T_RP, "R4 precharge", ras_hi_run, T_RP);
            end
            if (!prev_ras && ras_n)
                chk(ras_lo_run == T_RAS, "R4 ras width", ras_lo_run, T_RAS);
            if (!ras_n || !cas_n) begin
                chk(we_n && oe_n, "R5 we/oe high", {we_n, oe_n}, 3);
                chk(ref_gnt, "R6 strobe needs grant", ref_gnt, 1);
            end
            if (deadline_miss) miss_seen = 1'b1;
        end
        cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
        ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
        ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    task automatic do_reset();
        rst_n = 1'b0;
        allow = 1'b1;
        repeat (4) @(negedge clk);
        chk(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
        chk(!init_done && !ref_req, "R1 idle in reset", {init_done, ref_req}, 0);
        rst_n = 1'b1;
        falls = 0;
    endtask

    task automatic wait_init();
        for (int i = 0; i < 2000 && !init_done; i++) @(negedge clk);
    endtask

    initial begin
        // R1: exact pause length, quiet strobes.
        do_reset();
        for (int k = 1; k < PAUSE_CYC; k++) begin
            @(negedge clk);
            if (ref_req || !ras_n || !cas_n) chk(0, "R1 quiet pause", k, PAUSE_CYC);
        end
        @(negedge clk);
        chk(ref_req == 1'b1, "R1 request after pause", ref_req, 1);

        // R6/R10: grant withheld during wake-up, request held, strobes idle.
        allow = 1'b0;
        repeat (30) @(negedge clk);
        chk(ras_n && cas_n, "R6 no strobe without grant", {ras_n, cas_n}, 3);
        chk(ref_req && !init_done, "R10 request held", {ref_req, init_done}, 2);
        chk(falls == 0, "R6 no cycles without grant", falls, 0);
        allow = 1'b1;
        wait_init();
        chk(init_done, "R2 init completes", init_done, 1);
        chk(falls == WAKE_CYC, "R2 wake cycle count", falls, WAKE_CYC);

        // Table: withhold the grant for n intervals plus a margin, then release.
        for (int v = 0; v < NV; v++) begin
            int snap;
            do_reset();
            wait_init();
            chk(falls == WAKE_CYC, "R2 wake count per row", falls, WAKE_CYC);
            allow = 1'b0;
            miss_seen = 1'b0;
            repeat (V_INTV[v] * REF_INT + 10) @(negedge clk);
            snap = falls;
            allow = 1'b1;
            repeat (80) @(negedge clk);
            if (V_MISS[v] != 0) begin
                chk(falls - snap == V_EXP[v], "R9 rewake cycles", falls - snap, V_EXP[v]);
                chk(miss_seen, "R9 miss pulse", miss_seen, 1);
                chk(init_done, "R9 init restored", init_done, 1);
            end else begin
                chk(falls - snap == V_EXP[v], "R8 drained cycles", falls - snap, V_EXP[v]);
                chk(!miss_seen, "R8 no miss", miss_seen, 0);
                chk(!ref_req, "R10 request drops", ref_req, 0);
            end
        end

        // R7: refresh spacing with the grant always given.
        do_reset();
        wait_init();
        repeat (250) @(negedge clk);
        chk(falls == WAKE_CYC + 2, "R7 refreshes in span", falls, WAKE_CYC + 2);
        chk(t_last - t_prev == REF_INT, "R7 interval", t_last - t_prev, REF_INT);

        finish_run();
    end
endmodule